// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block sits between a processor's load/store unit and a 32-bit system bus. The processor hands it a single operand access of one, two or four bytes. The access may start at any byte address. The block then runs as many bus cycles as that access needs. It does not know in advance how wide the addressed slave is. Each slave ends a cycle by returning a two-bit width code, and from that code the master works out how many bytes moved. If bytes are left over, the master starts the next cycle straight away at the next address that has not been covered. An operand can therefore cross from an 8-bit region into a 16-bit region, or cross a word boundary, with no software help.

On writes, the bytes still to be sent are driven onto the data lanes so that a slave of any width finds its bytes where it expects them. On reads, the bytes returned in each cycle are shifted into an accumulator. When the last cycle completes, the accumulator is copied to a right-justified result register and a one-clock completion pulse is raised.

Top module: `dsz_bus_master`

## Requirements
- R1: While reset is high and on the first clock after it, `bus_strobe` and `done` are low and `rd_data` is zero.
- R2: With the bus idle, a high `req_start` is sampled on a rising edge. On the next clock `bus_strobe` is high, `bus_addr` equals `req_addr`, `bus_write` equals `req_write`, and `bus_remain` holds the operand length. Size code 00 gives 1 byte, 01 gives 2 bytes, and 10 or 11 give 4 bytes. Write data is taken right-justified from `req_wdata`.
- R3: `bus_ack` code 00 means wait. While it is 00 the cycle holds its address, data, direction and remaining count. Codes 01, 10 and 11 mean the slave is 8, 16 or 32 bits wide. A cycle ends on the first rising edge that samples a nonzero code.
- R4: A completed cycle moves n = min(remaining, W − (address mod W)) bytes, where W is the port width in bytes. If bytes remain, the next cycle follows on the very next clock, with the address raised by n and the remaining count lowered by n.
- R5: Bytes are big-endian. Lane 0 is bits 31:24 and the lowest address carries the most significant operand byte. On writes, the byte for address A is on lane A mod 4 for a 32-bit slave, lane A mod 2 for a 16-bit slave and lane 0 for a byte slave, and this holds at the same time for all three widths.
- R6: After a read, `rd_data` holds the operand right-justified, with the byte at the lowest address as the most significant byte. Bytes above the operand are zero. Read lanes outside the bytes that moved are ignored.
- R7: `done` is high for exactly one clock, starting on the clock after the last acknowledged edge. `bus_strobe` is low during that clock. `rd_data` changes only in a `done` clock and only on a read. A write leaves it unchanged.
- R8: `req_start` has no effect while `bus_strobe` is high. The current transfer finishes with its own address and data, and no extra transfer follows.
- R9: A request presented during the `done` clock is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse for one operand access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | DATA_W | Write operand, right-justified |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Direction of the current cycle |
| bus_addr | output | ADDR_W | Address of the first byte still to move |
| bus_wdata | output | DATA_W | Steered write data |
| bus_remain | output | 3 | Bytes of the operand still to move |
| bus_ack | input | 2 | Slave width acknowledge (00 wait) |
| bus_rdata | input | DATA_W | Read data from the slave |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Assembled read result |

## Verification
The first bus cycle is due on the clock after the start edge. Each bus cycle then takes one clock plus the wait clocks its slave inserts. `done` follows one clock after the last acknowledge, so a request started at clock t must report done at t + 1 + Σ(1 + waits). The bench computes that figure from the width formula in R4, using the same address map as its slave model. It samples everything on falling edges and compares the cycle counter at the `done` pulse against that figure. The first-cycle address, direction and count are checked one clock after each start. Read results and the bytes that reached slave memory are compared at the `done` clock.

// File: rtl/dsz_pkg.sv
package dsz_pkg;

  localparam int CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    ACK_WAIT = 2'b00,
    ACK_P8   = 2'b01,
    ACK_P16  = 2'b10,
    ACK_P32  = 2'b11
  } ack_e;

  // operand length in bytes from the request size code
  function automatic cnt_t size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return cnt_t'(1);
      2'b01:   return cnt_t'(2);
      default: return cnt_t'(4);
    endcase
  endfunction

  // port width in bytes from the acknowledge code
  function automatic cnt_t port_bytes(input logic [1:0] ack);
    case (ack)
      2'b01:   return cnt_t'(1);
      2'b10:   return cnt_t'(2);
      2'b11:   return cnt_t'(4);
      default: return cnt_t'(0);
    endcase
  endfunction

endpackage

// File: rtl/dsz_step_calc.sv
module dsz_step_calc
  import dsz_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  cnt_t       remain,
  input  logic [1:0] ack,
  output cnt_t       step,
  output logic [1:0] lane_off,
  output logic       last
);

  cnt_t width_b;
  cnt_t room;

  always_comb begin
    width_b = port_bytes(ack);
    case (ack)
      ACK_P8:  lane_off = 2'd0;
      ACK_P16: lane_off = {1'b0, addr_lo[0]};
      default: lane_off = addr_lo;
    endcase
    room = width_b - cnt_t'(lane_off);
    if (ack == ACK_WAIT)   step = '0;
    else if (remain < room) step = remain;
    else                    step = room;
    last = (ack != ACK_WAIT) && (step == remain);
  end

endmodule

// File: rtl/dsz_wr_steer.sv
module dsz_wr_steer #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] pend,
  input  logic [1:0]        off,
  output logic [DATA_W-1:0] lanes_out
);

  localparam int LANES = DATA_W / 8;
  localparam int HALF  = 2;

  // source byte (of the left-justified pending data) for output lane j
  function automatic int src_of(input int j, input int o);
    if (j >= o) return j - o;
    if (j < HALF && j >= (o % HALF)) return j - (o % HALF);
    return 0;
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lanes_out[DATA_W-1-8*j -: 8] = pend[DATA_W-1-8*src_of(j, int'(off)) -: 8];
  end

endmodule

// File: rtl/dsz_rd_merge.sv
module dsz_rd_merge
  import dsz_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        lane_off,
  input  cnt_t              step,
  output logic [DATA_W-1:0] acc_next
);

  localparam int SH_W = $clog2(DATA_W) + 1;

  logic [SH_W-1:0]   sh_lane;
  logic [SH_W-1:0]   sh_take;
  logic [SH_W-1:0]   sh_drop;
  logic [DATA_W-1:0] aligned;

  assign sh_lane  = SH_W'({lane_off, 3'b000});
  assign sh_take  = SH_W'({step, 3'b000});
  assign sh_drop  = SH_W'(DATA_W) - sh_take;
  // first valid lane moved to the top, then only `step` bytes kept
  assign aligned  = rdata << sh_lane;
  assign acc_next = (acc << sh_take) | (aligned >> sh_drop);

endmodule

// File: rtl/dsz_bus_master.sv
module dsz_bus_master
  import dsz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [2:0]        bus_remain,
  input  logic [1:0]        bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SH_W = $clog2(DATA_W) + 1;

  logic              strobe_q;
  logic              write_q;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  cnt_t              remain_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] rd_q;

  cnt_t              req_bytes;
  cnt_t              step;
  logic [1:0]        lane_off;
  logic              last;
  logic              accept;
  logic              hit;
  logic [SH_W-1:0]   sh_load;
  logic [SH_W-1:0]   sh_step;
  logic [DATA_W-1:0] acc_next;

  assign req_bytes = size_bytes(req_size);
  assign sh_load   = SH_W'(DATA_W) - SH_W'({req_bytes, 3'b000});
  assign sh_step   = SH_W'({step, 3'b000});
  assign accept    = req_start && !strobe_q;
  assign hit       = strobe_q && (bus_ack != ACK_WAIT);

  dsz_step_calc u_step (
    .addr_lo  (addr_q[1:0]),
    .remain   (remain_q),
    .ack      (bus_ack),
    .step     (step),
    .lane_off (lane_off),
    .last     (last)
  );

  dsz_wr_steer #(.DATA_W(DATA_W)) u_steer (
    .pend      (pend_q),
    .off       (addr_q[1:0]),
    .lanes_out (bus_wdata)
  );

  dsz_rd_merge #(.DATA_W(DATA_W)) u_merge (
    .acc      (acc_q),
    .rdata    (bus_rdata),
    .lane_off (lane_off),
    .step     (step),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      write_q  <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      pend_q   <= '0;
      acc_q    <= '0;
      rd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        strobe_q <= 1'b1;
        write_q  <= req_write;
        addr_q   <= req_addr;
        remain_q <= req_bytes;
        pend_q   <= req_wdata << sh_load;
        acc_q    <= '0;
      end else if (hit) begin
        addr_q   <= addr_q + ADDR_W'(step);
        remain_q <= remain_q - step;
        pend_q   <= pend_q << sh_step;
        acc_q    <= acc_next;
        if (last) begin
          strobe_q <= 1'b0;
          done_q   <= 1'b1;
          if (!write_q) rd_q <= acc_next;
        end
      end
    end
  end

  assign bus_strobe = strobe_q;
  assign bus_write  = write_q;
  assign bus_addr   = addr_q;
  assign bus_remain = remain_q;
  assign done       = done_q;
  assign rd_data    = rd_q;

endmodule

// File: rtl/dsz_bus_master_chk.sv
module dsz_bus_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_start,
  input logic              bus_strobe,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [2:0]        bus_remain,
  input logic [1:0]        bus_ack,
  input logic              done,
  input logic [DATA_W-1:0] rd_data
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_strobe);

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_ack == 2'b00) |=>
      (bus_strobe && $stable(bus_addr) && $stable(bus_remain)
       && $stable(bus_wdata) && $stable(bus_write)));

  assert_remain_range_R2: assert property (@(posedge clk) disable iff (rst)
    bus_strobe |-> (bus_remain != 3'd0 && bus_remain <= 3'd4));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_ack != 2'b00) |=>
      (!bus_strobe || ((bus_addr - $past(bus_addr)) ==
                       ADDR_W'($past(bus_remain) - bus_remain))));

  assert_byte_port_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_ack == 2'b01) |=>
      (!bus_strobe || bus_remain == $past(bus_remain) - 3'd1));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && req_start && bus_ack == 2'b00) |=> $stable(bus_addr));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> done);

endmodule

bind dsz_bus_master dsz_bus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_start  (req_start),
  .bus_strobe (bus_strobe),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_remain (bus_remain),
  .bus_ack    (bus_ack),
  .done       (done),
  .rd_data    (rd_data)
);

// File: tb/dsz_bus_master_tb_top.sv
`timescale 1ns/1ps
module dsz_bus_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_strobe;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [2:0]  bus_remain;
  logic [1:0]  bus_ack = 2'b00;
  logic [31:0] bus_rdata = 32'hEEEEEEEE;
  logic        done;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  dsz_bus_master dut_i (
    .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_remain(bus_remain), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .done(done), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // ---------------- slave model: 64 bytes, width by address bits 5:4 ----------
  logic [7:0] mem    [64];
  logic [7:0] shadow [64];
  int wcnt = 0;

  function automatic int width_of(input int a);
    case ((a % 64) / 16)
      0:       return 1;
      1:       return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int waits_of(input int a);
    return ((a % 64) / 16 == 3) ? 2 : 0;
  endfunction

  function automatic logic [1:0] code_of(input int w);
    return (w == 1) ? 2'b01 : (w == 2) ? 2'b10 : 2'b11;
  endfunction

  always @(negedge clk) begin
    if (rst || !bus_strobe) begin
      bus_ack   = 2'b00;
      bus_rdata = 32'hEEEEEEEE;
      wcnt      = 0;
    end else begin
      int a;
      int w;
      a = int'(bus_addr[5:0]);
      w = width_of(a);
      if (wcnt < waits_of(a)) begin
        bus_ack   = 2'b00;
        bus_rdata = 32'hEEEEEEEE;
        wcnt++;
      end else begin
        bus_ack   = code_of(w);
        bus_rdata = 32'hEEEEEEEE;
        for (int j = 0; j < w; j++)
          bus_rdata[31-8*j -: 8] = mem[(a - (a % w)) + j];
        wcnt = 0;
      end
    end
  end

  // write side: only the bytes of this cycle land in memory (R4 count, R5 lanes)
  always @(posedge clk) begin
    if (!rst && bus_strobe && bus_ack != 2'b00 && bus_write) begin
      int a;
      int w;
      int o;
      int n;
      a = int'(bus_addr[5:0]);
      w = (bus_ack == 2'b01) ? 1 : (bus_ack == 2'b10) ? 2 : 4;
      o = a % w;
      n = (int'(bus_remain) < (w - o)) ? int'(bus_remain) : (w - o);
      for (int i = 0; i < n; i++)
        mem[(a + i) % 64] = bus_wdata[31-8*(o+i) -: 8];
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          wr;
    int          addr;
    int          nb;
    logic [31:0] exp;
    int          t0;
    int          lat;
  } item_t;

  item_t sbq[$];
  logic [31:0] last_rd = '0;

  always @(negedge clk) begin
    if (!rst && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R7", "done without request", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(cyc - it.t0 == it.lat, "R4", "latency to done",
              32'(cyc - it.t0), 32'(it.lat));
        if (!it.wr) begin
          check(rd_data == it.exp, "R6", "read result", rd_data, it.exp);
          last_rd = it.exp;
        end else begin
          logic [31:0] got;
          got = '0;
          for (int k = 0; k < it.nb; k++)
            got = (got << 8) | 32'(mem[(it.addr + k) % 64]);
          check(got == it.exp, "R5", "written bytes", got, it.exp);
          check(rd_data == last_rd, "R7", "rd_data kept over write", rd_data, last_rd);
        end
      end
    end
  end

  task automatic op(input bit wr, input logic [1:0] sz, input int addr,
                    input logic [31:0] data, input bit poke);
    item_t it;
    int nb;
    int a;
    int r;
    int total;
    nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    it.wr = wr;
    it.addr = addr;
    it.nb = nb;
    if (wr) begin
      it.exp = (nb == 4) ? data : (data & ((32'd1 << (8*nb)) - 1));
      for (int k = 0; k < nb; k++)
        shadow[(addr + k) % 64] = it.exp[8*(nb-1-k) +: 8];
    end else begin
      it.exp = '0;
      for (int k = 0; k < nb; k++)
        it.exp = (it.exp << 8) | 32'(shadow[(addr + k) % 64]);
    end
    total = 0;
    a = addr;
    r = nb;
    while (r > 0) begin
      int w;
      int n;
      w = width_of(a);
      n = (r < (w - a % w)) ? r : (w - a % w);
      total += 1 + waits_of(a);
      a += n;
      r -= n;
    end
    it.t0 = cyc;
    it.lat = total + 1;
    sbq.push_back(it);
    req_start = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = 32'(addr);
    req_wdata = data;
    @(negedge clk);
    req_start = 1'b0;
    req_addr  = 32'hDEAD_0000;
    req_wdata = 32'h5A5A5A5A;
    check(bus_strobe && bus_addr == 32'(addr) && bus_write == wr,
          "R2", "first cycle address", bus_addr, 32'(addr));
    check(bus_remain == 3'(nb), "R2", "first cycle length",
          32'(bus_remain), 32'(nb));
    if (poke) begin
      req_start = 1'b1;
      req_write = ~wr;
      req_addr  = 32'h0000_0031;
      @(negedge clk);
      req_start = 1'b0;
    end
    for (int g = 0; g < 100 && !done; g++) @(negedge clk);
    if (poke) begin
      for (int g = 0; g < 4; g++) begin
        @(negedge clk);
        check(!bus_strobe && !done, "R8", "no transfer after ignored start",
              32'({bus_strobe, done}), 32'd0);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    check(!bus_strobe && !done && rd_data == '0, "R1", "state in reset",
          32'({bus_strobe, done}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_strobe && !done && rd_data == '0, "R1", "state after reset",
          rd_data, 32'd0);

    op(1'b0, 2'b00, 6'h05, '0, 1'b0);              // R6 byte from byte port
    op(1'b0, 2'b10, 6'h02, '0, 1'b0);              // R4 four byte-port cycles
    op(1'b0, 2'b01, 6'h13, '0, 1'b0);              // R4 odd word on 16-bit port
    op(1'b0, 2'b10, 6'h11, '0, 1'b0);              // R4 1+2+1 split
    op(1'b0, 2'b10, 6'h20, '0, 1'b0);              // R6 aligned 32-bit
    op(1'b0, 2'b10, 6'h23, '0, 1'b0);              // R4 misaligned 32-bit
    op(1'b0, 2'b10, 6'h32, '0, 1'b0);              // R3 waits
    op(1'b0, 2'b10, 6'h0E, '0, 1'b0);              // R4 8-bit into 16-bit region
    op(1'b1, 2'b10, 6'h21, 32'hA1B2C3D4, 1'b0);    // R5 32-bit port offset 1
    op(1'b0, 2'b10, 6'h21, '0, 1'b0);              // R9 back to back read-back
    op(1'b1, 2'b10, 6'h08, 32'h11223344, 1'b0);    // R5 byte port
    op(1'b0, 2'b10, 6'h08, '0, 1'b0);
    op(1'b1, 2'b01, 6'h17, 32'hFFFF9876, 1'b0);    // R5 16-bit port odd
    op(1'b0, 2'b01, 6'h17, '0, 1'b0);
    op(1'b1, 2'b00, 6'h3F, 32'h000000C7, 1'b0);    // R3 byte write with waits
    op(1'b0, 2'b00, 6'h3F, '0, 1'b0);
    op(1'b1, 2'b10, 6'h2E, 32'h0BADF00D, 1'b0);    // R5 crossing into wait region
    op(1'b0, 2'b10, 6'h2E, '0, 1'b0);
    op(1'b0, 2'b11, 6'h24, '0, 1'b0);              // R2 size code 11 = 4 bytes
    op(1'b0, 2'b10, 6'h00, '0, 1'b1);              // R8 start while busy

    check(sbq.size() == 0, "R7", "every request completed",
          32'(sbq.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", 32'(cyc), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule